// File: doc/BRIEF.md
# External Pulse Width Event Timer

This block measures how long an external signal stays at a chosen level. The external input comes from outside the clock domain. It is first brought in through a two-stage synchronizer. After that, an internal counter advances by one on every system clock cycle in which the synchronized level matches the selected phase. The selected phase is either high or low. When the phase ends, the accumulated count is copied into an event register, and a one-cycle event interrupt pulse is raised. The event register holds its value until the next completed phase, so it can be read at leisure.

Typical uses are decoding a PWM stream (measure the high time, or the low time) and timing single events. The counter restarts at the start of every new phase, so each captured value covers exactly one pulse. A configuration input chooses what happens during a very long phase:

- **Wrap:** the counter rolls over to zero and keeps counting.
- **Stop:** the counter holds at full scale.

In both cases an overflow interrupt pulse marks the event. Measurements happen only while the enable input is high. A phase that is already running when the block is enabled is ignored, and so is a phase that is interrupted by disabling the block. A synchronous clear input abandons any measurement in progress and zeroes the event register.

Top module: `pulse_event_timer`

## Requirements
- R1: The external input passes through two synchronizer flip-flops. The event interrupt and the new event register value appear after the third rising clock edge that follows the first edge sampling the out-of-phase level, and not after the second.
- R2: With `phase_hi_i`=1, the captured value equals the number of rising clock edges at which `ext_i` was sampled high during the pulse.
- R3: With `phase_hi_i`=0, the captured value equals the number of rising clock edges at which `ext_i` was sampled low during the pulse.
- R4: `evt_irq_o` is high for exactly one cycle per completed measurement, in the same cycle in which `event_o` takes the new value.
- R5: The counter restarts at the start of every selected phase, so consecutive pulses of different widths are each captured with their own width.
- R6: With `ovf_wrap_i`=1, the counter wraps from 2^CNT_W-1 to 0 and continues. `ovf_irq_o` pulses once per wrap, and the captured value is the width modulo 2^CNT_W.
- R7: With `ovf_wrap_i`=0, the counter holds at 2^CNT_W-1, `ovf_irq_o` pulses once per phase, and the captured value is 2^CNT_W-1.
- R8: A phase during which `en_i` goes low is not captured: `event_o` keeps its value and `evt_irq_o` stays low.
- R9: A phase that is already in progress when `en_i` rises is not captured. The next complete phase is captured normally.
- R10: A one-cycle `clr_i` sets `event_o` to 0 on the next edge and abandons any measurement in progress, so that phase produces no event.
- R11: After reset, `event_o` is 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all counting is in cycles of this clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | 1 | Asynchronous external signal being measured |
| en_i | input | 1 | Timer enable |
| clr_i | input | 1 | Synchronous clear of the measurement and the event register |
| phase_hi_i | input | 1 | 1: count while the input is high; 0: count while it is low |
| ovf_wrap_i | input | 1 | 1: wrap on overflow; 0: stop at full scale |
| event_o | output | CNT_W | Count captured at the end of the last completed phase |
| evt_irq_o | output | 1 | One-cycle pulse when a measurement completes |
| ovf_irq_o | output | 1 | One-cycle pulse when the counter overflows |

## Verification
A level change on `ext_i` reaches the phase logic two edges after it is first sampled, and the capture register adds one more edge. The event result is therefore due after the third edge. The bench drives the input on falling edges, counts exact edges, and samples on the falling edge after the second and after the third edge: the pulse must be absent at the first point and present at the second. A clear takes effect after one edge and is sampled on the next falling edge. Overflow pulses and event pulses are tallied on every falling edge, so the "exactly once" and "never" checks are made over the whole window of each phase.

// File: rtl/pet_pkg.sv
package pet_pkg;
    localparam int unsigned PET_CNT_W       = 16;
    localparam int unsigned PET_SYNC_STAGES = 2;
endpackage

// File: rtl/pet_sync.sv
module pet_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb st_d = async_i;
        end else begin : g_chain
            always_comb st_d = {st_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/pet_counter.sv
module pet_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lvl_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             phase_hi_i,
    input  logic             ovf_wrap_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             stopped;
        logic             prev_act;
        logic             ovf;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    act, start, fin;

    always_comb begin
        act   = (lvl_i == phase_hi_i);
        start = act & ~st_q.prev_act;
        fin   = ~act & st_q.prev_act;

        st_d          = st_q;
        st_d.prev_act = act;
        st_d.ovf      = 1'b0;

        if (clr_i) begin
            st_d.cnt      = '0;
            st_d.armed    = 1'b0;
            st_d.stopped  = 1'b0;
            st_d.prev_act = 1'b1;
        end else if (!en_i) begin
            st_d.armed = 1'b0;
        end else if (start) begin
            st_d.armed   = 1'b1;
            st_d.stopped = 1'b0;
            st_d.cnt     = CNT_ONE;
        end else if (fin) begin
            st_d.armed = 1'b0;
        end else if (act && st_q.armed) begin
            if (st_q.cnt == CNT_MAX) begin
                if (ovf_wrap_i) begin
                    st_d.cnt = '0;
                    st_d.ovf = 1'b1;
                end else if (!st_q.stopped) begin
                    st_d.stopped = 1'b1;
                    st_d.ovf     = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt      <= '0;
            st_q.armed    <= 1'b0;
            st_q.stopped  <= 1'b0;
            st_q.prev_act <= 1'b1;
            st_q.ovf      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = fin & st_q.armed & en_i & ~clr_i;
    assign ovf_o  = st_q.ovf;

    // R7: in stop mode a full counter stays at full scale
    a_r7_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clr_i && !ovf_wrap_i && st_q.armed && act && !start && st_q.cnt == CNT_MAX)
        |=> (st_q.cnt == CNT_MAX));

    // R6: in wrap mode a full counter rolls to zero and flags overflow
    a_r6_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clr_i && ovf_wrap_i && st_q.armed && act && !start && st_q.cnt == CNT_MAX)
        |=> (st_q.cnt == '0 && st_q.ovf));

    // R8: disabling drops any measurement in progress
    a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !st_q.armed);

    // R6, R7: an overflow pulse only follows a full counter
    a_r6_ovf_from_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |-> $past(st_q.cnt) == CNT_MAX);
endmodule

// File: rtl/pet_capture.sv
module pet_capture #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] event_o,
    output logic             evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             evt;
    } cap_st_t;

    cap_st_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.evt = 1'b0;
        if (clr_i) begin
            cap_d.val = '0;
        end else if (done_i) begin
            cap_d.val = cnt_i;
            cap_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign event_o = cap_q.val;
    assign evt_o   = cap_q.evt;

    // R4: event pulse lasts one cycle
    a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q.evt |=> !cap_q.evt);

    // R4: the register changes only with an event or a clear
    a_r4_change_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cap_q.val) |-> ($past(done_i) || $past(clr_i)));

    // R10: clear zeroes the register
    a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cap_q.val == '0 && !cap_q.evt));
endmodule

// File: rtl/pulse_event_timer.sv
module pulse_event_timer #(
    parameter int unsigned CNT_W       = pet_pkg::PET_CNT_W,
    parameter int unsigned SYNC_STAGES = pet_pkg::PET_SYNC_STAGES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             phase_hi_i,
    input  logic             ovf_wrap_i,
    output logic [CNT_W-1:0] event_o,
    output logic             evt_irq_o,
    output logic             ovf_irq_o
);
    logic             lvl;
    logic [CNT_W-1:0] cnt;
    logic             done;

    pet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_i),
        .sync_o  (lvl)
    );

    pet_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lvl_i      (lvl),
        .en_i       (en_i),
        .clr_i      (clr_i),
        .phase_hi_i (phase_hi_i),
        .ovf_wrap_i (ovf_wrap_i),
        .cnt_o      (cnt),
        .done_o     (done),
        .ovf_o      (ovf_irq_o)
    );

    pet_capture #(.CNT_W(CNT_W)) u_capture (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .done_i  (done),
        .cnt_i   (cnt),
        .event_o (event_o),
        .evt_o   (evt_irq_o)
    );

    // R8: no event can follow a cycle with the timer disabled
    a_r8_no_event_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !evt_irq_o);
endmodule

// File: tb/pulse_event_timer_tb.sv
module pulse_event_timer_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ext, en, clr, ph, wrap;
    logic [W-1:0] event_o;
    logic         evt_irq_o, ovf_irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int evt_seen = 0;
    int ovf_seen = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_event_timer #(.CNT_W(W)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ext_i      (ext),
        .en_i       (en),
        .clr_i      (clr),
        .phase_hi_i (ph),
        .ovf_wrap_i (wrap),
        .event_o    (event_o),
        .evt_irq_o  (evt_irq_o),
        .ovf_irq_o  (ovf_irq_o)
    );

    localparam int NV = 6;
    localparam logic VPH  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int   VW   [NV] = '{5, 1, 17, 9, 2, 40};
    localparam int   VEXP [NV] = '{5, 1, 17, 9, 2, 40};

    always @(negedge clk) begin
        if (evt_irq_o) evt_seen++;
        if (ovf_irq_o) ovf_seen++;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One pulse of w cycles at level p; result due after the 3rd edge (R1)
    task automatic measure(input logic p, input int w, input int exp_v, input string tag);
        int e0;
        e0 = evt_seen;
        @(negedge clk); ext = p;
        repeat (w) @(posedge clk);
        @(negedge clk); ext = ~p;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(evt_irq_o == 1'b0, "R1 early", int'(evt_irq_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk(evt_irq_o == 1'b1, {tag, " R1 event due"}, int'(evt_irq_o), 1);
        chk(int'(event_o) == exp_v, tag, int'(event_o), exp_v);
        @(negedge clk);
        chk(evt_irq_o == 1'b0 && evt_seen == e0 + 1, "R4 single pulse", evt_seen - e0, 1);
        idle(3);
    endtask

    task automatic set_phase(input logic p);
        en = 1'b0; ph = p; ext = ~p;
        idle(4);
        en = 1'b1;
        idle(2);
    endtask

    initial begin
        int last, e0;
        rst_n = 1'b0; ext = 1'b0; en = 1'b0; clr = 1'b0; ph = 1'b1; wrap = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(event_o == '0, "R11 event", int'(event_o), 0);
        chk(evt_irq_o == 1'b0 && ovf_irq_o == 1'b0, "R11 irq", int'({evt_irq_o, ovf_irq_o}), 0);
        en = 1'b1;
        idle(4);

        // R2 / R3 table walk
        for (int i = 0; i < NV; i++) begin
            if (VPH[i] != ph) set_phase(VPH[i]);
            measure(VPH[i], VW[i], VEXP[i], VPH[i] ? "R2 high phase" : "R3 low phase");
        end

        // R5 back-to-back pulses restart the count
        measure(1'b1, 30, 30, "R5 first");
        measure(1'b1, 7, 7, "R5 second");

        // R6 wrap: 600 cycles -> 600 mod 256 = 88, two wraps
        wrap = 1'b1;
        @(posedge clk); ovf_seen = 0;
        measure(1'b1, 600, 88, "R6 wrap value");
        chk(ovf_seen == 2, "R6 wrap count", ovf_seen, 2);

        // R7 stop: saturates at 255, one overflow
        @(negedge clk); wrap = 1'b0;
        @(posedge clk); ovf_seen = 0;
        measure(1'b1, 600, 255, "R7 stop value");
        chk(ovf_seen == 1, "R7 stop count", ovf_seen, 1);
        wrap = 1'b1;

        // R8 disable mid-phase
        last = int'(event_o); e0 = evt_seen;
        @(negedge clk); ext = 1'b1;
        idle(10); en = 1'b0;
        idle(5); ext = 1'b0;
        idle(6);
        chk(evt_seen == e0, "R8 no event", evt_seen - e0, 0);
        chk(int'(event_o) == last, "R8 held", int'(event_o), last);
        en = 1'b1;
        idle(3);

        // R9 enabled mid-phase
        e0 = evt_seen;
        en = 1'b0; @(negedge clk); ext = 1'b1;
        idle(4); en = 1'b1;
        idle(10); ext = 1'b0;
        idle(6);
        chk(evt_seen == e0, "R9 no event", evt_seen - e0, 0);
        chk(int'(event_o) == last, "R9 held", int'(event_o), last);
        measure(1'b1, 12, 12, "R9 next phase");

        // R10 clear register, then clear mid-phase
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(event_o == '0, "R10 cleared", int'(event_o), 0);
        e0 = evt_seen;
        ext = 1'b1;
        idle(8); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        idle(5); ext = 1'b0;
        idle(6);
        chk(evt_seen == e0 && event_o == '0, "R10 abandoned", evt_seen - e0, 0);
        measure(1'b1, 3, 3, "R10 after clear");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule